// File: doc/BRIEF.md
# Broadcast Command History Filter

This block keeps a running log of short broadcast commands, each one byte wide. Every command that arrives with its valid strobe is stamped with the orbit and bunch counters present in the same cycle. The stamped record is written to a fixed-depth history memory at the next free slot, and a stored-entry count advances by one.

A list of sixteen filter entries stands in front of the memory. Each entry carries a command value, a mask in which a 1 marks a bit that is left out of the comparison, and an enable bit. While filtering is on, a command that matches any enabled entry is dropped and not logged. Capture and filtering each have their own enable. A clear strobe empties the log. A registered read port returns any stored record one cycle after its address is presented, and the stored count is always visible.

Top module: `cmd_history_filter`

## Requirements
- R1: After reset the stored count is 0 and every filter entry is disabled, so with filtering on, any command is stored.
- R2: An accepted command is written at address `count` (the first at address 0, then in arrival order). The record holds the command byte, plus the orbit and bunch values sampled on the same clock edge.
- R3: The read outputs show the record at `rd_addr` one clock after that address is applied.
- R4: With filtering on, a command is dropped when an enabled entry satisfies `((cmd ^ value) & ~mask) == 0`. The filter word lays out as follows: bits 7:0 hold the value, bits 15:8 hold the mask (1 = ignore that bit), and bit 16 is the enable.
- R5: A filter entry whose enable bit is 0 never causes a drop.
- R6: With filtering off, every command is stored whatever the filter contents.
- R7: With capture off, no command is stored and the count does not change.
- R8: A clear sets the count to 0 on the next edge. A command presented in the same cycle as a clear is not stored.
- R9: Once DEPTH records are held, the count stays at DEPTH, further commands are not written, and the held records are unchanged.
- R10: A filter write takes effect for commands presented from the following cycle on. A rewritten entry replaces its old contents.
- R11: The count rises by exactly one for each stored command and otherwise holds, except on a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_byte | input | 8 | Command code |
| orbit | input | ORB_W | Orbit counter to stamp |
| bx | input | BX_W | Bunch counter to stamp |
| flt_we | input | 1 | Filter entry write strobe |
| flt_addr | input | $clog2(NFILT) | Filter entry index |
| flt_wdata | input | 17 | Filter word: value, mask, enable |
| capture_en | input | 1 | Capture enable |
| filter_en | input | 1 | Filter enable |
| clear | input | 1 | Empty the log |
| rd_addr | input | $clog2(DEPTH) | Read address |
| rd_cmd | output | 8 | Stored command byte |
| rd_orbit | output | ORB_W | Stored orbit stamp |
| rd_bx | output | BX_W | Stored bunch stamp |
| count | output | $clog2(DEPTH+1) | Number of stored records |

## Verification
The bench builds the block with DEPTH=8 and leaves NFILT, ORB_W and BX_W at their defaults of 16, 16 and 12. A depth of eight lets a short run fill the log, so saturation and the untouched-after-full records can be checked without thousands of commands. The full sixteen-entry filter stays in place, so the masked-match, disabled-entry and rewrite cases run against the real list width.

// File: rtl/cmd_history_filter.sv
module cmd_history_filter #(
  parameter int DEPTH = 512,
  parameter int NFILT = 16,
  parameter int ORB_W = 16,
  parameter int BX_W  = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_valid,
  input  logic [7:0]                 cmd_byte,
  input  logic [ORB_W-1:0]           orbit,
  input  logic [BX_W-1:0]            bx,
  input  logic                       flt_we,
  input  logic [$clog2(NFILT)-1:0]   flt_addr,
  input  logic [16:0]                flt_wdata,
  input  logic                       capture_en,
  input  logic                       filter_en,
  input  logic                       clear,
  input  logic [$clog2(DEPTH)-1:0]   rd_addr,
  output logic [7:0]                 rd_cmd,
  output logic [ORB_W-1:0]           rd_orbit,
  output logic [BX_W-1:0]            rd_bx,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int CMD_W = 8;
  localparam int FE_W  = 2*CMD_W + 1;
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = $clog2(DEPTH+1);
  localparam int EW    = CMD_W + ORB_W + BX_W;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [FE_W-1:0]  flt [NFILT];
  logic [NFILT-1:0] hitv;
  logic [EW-1:0]    mem [DEPTH];
  logic [EW-1:0]    rd_q;
  logic             dropped, full, store;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NFILT; i++) flt[i] <= '0;
    end else if (flt_we) begin
      flt[flt_addr] <= flt_wdata;
    end
  end

  for (genvar g = 0; g < NFILT; g++) begin : g_match
    assign hitv[g] = flt[g][FE_W-1] &&
      (((cmd_byte ^ flt[g][CMD_W-1:0]) & ~flt[g][2*CMD_W-1:CMD_W]) == '0);
  end

  assign dropped = filter_en && (|hitv);
  assign full    = (count == FULL);
  assign store   = cmd_valid && capture_en && !dropped && !full && !clear;

  always_ff @(posedge clk) begin
    if (store) mem[count[AW-1:0]] <= {cmd_byte, orbit, bx};
    rd_q <= mem[rd_addr];
  end

  assign {rd_cmd, rd_orbit, rd_bx} = rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     count <= '0;
    else if (clear) count <= '0;
    else if (store) count <= count + 1'b1;
  end

  a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (count == '0));

  a_r9_never_over: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL);

  a_r9_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !clear) |=> $stable(count));

  a_r7_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!capture_en && !clear) |=> $stable(count));

  a_r4_drop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && dropped && !clear) |=> $stable(count));

  a_r11_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> ($stable(count) || count == $past(count) + 1'b1));
endmodule

// File: tb/tb_cmd_history_filter.sv
module tb_cmd_history_filter;
  localparam int TD = 8;
  localparam int TO = 16;
  localparam int TB = 12;
  localparam int NF = 16;

  logic clk = 0;
  logic rst_n = 0;
  logic cmd_valid = 0;
  logic [7:0] cmd_byte = '0;
  logic [TO-1:0] orbit = '0;
  logic [TB-1:0] bx = '0;
  logic flt_we = 0;
  logic [3:0] flt_addr = '0;
  logic [16:0] flt_wdata = '0;
  logic capture_en = 0;
  logic filter_en = 0;
  logic clear = 0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_cmd;
  logic [TO-1:0] rd_orbit;
  logic [TB-1:0] rd_bx;
  logic [3:0] count;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [16:0] mflt [NF];
  logic [35:0] sb [$];
  int cnt = 0, rd_base = 0;
  logic [TO-1:0] orb_n = 16'h0100;
  logic [TB-1:0] bx_n = 12'h005;

  always #10 clk = ~clk;

  cmd_history_filter #(.DEPTH(TD), .NFILT(NF), .ORB_W(TO), .BX_W(TB)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .orbit(orbit), .bx(bx), .flt_we(flt_we), .flt_addr(flt_addr),
    .flt_wdata(flt_wdata), .capture_en(capture_en), .filter_en(filter_en),
    .clear(clear), .rd_addr(rd_addr), .rd_cmd(rd_cmd), .rd_orbit(rd_orbit),
    .rd_bx(rd_bx), .count(count));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit model_hit(input logic [7:0] c);
    for (int i = 0; i < NF; i++)
      if (mflt[i][16] && (((c ^ mflt[i][7:0]) & ~mflt[i][15:8]) == 8'h00)) return 1;
    return 0;
  endfunction

  task automatic wr_flt(input int idx, input logic [7:0] val, input logic [7:0] msk, input bit en);
    @(negedge clk);
    flt_we = 1; flt_addr = idx[3:0]; flt_wdata = {en, msk, val};
    @(negedge clk);
    flt_we = 0;
    mflt[idx] = {en, msk, val};
  endtask

  task automatic send(input logic [7:0] c);
    @(negedge clk);
    cmd_valid = 1; cmd_byte = c; orbit = orb_n; bx = bx_n;
    if (capture_en && !(filter_en && model_hit(c)) && cnt < TD) begin
      sb.push_back({c, orb_n, bx_n});
      cnt++;
    end
    @(negedge clk);
    cmd_valid = 0;
    orb_n = orb_n + 16'd1;
    bx_n = bx_n + 12'd7;
  endtask

  task automatic drain(input string req);
    while (sb.size() > 0) begin
      logic [35:0] e;
      @(negedge clk);
      rd_addr = rd_base[2:0];
      @(negedge clk);
      e = sb.pop_front();
      chk(req, {rd_cmd, rd_orbit, rd_bx}, e);
      rd_base++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NF; i++) mflt[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 count after reset", count, 0);

    capture_en = 1; filter_en = 1;
    send(8'h01); send(8'h28);
    chk("R1 no entry enabled after reset", count, cnt);

    wr_flt(0, 8'h28, 8'h00, 1);
    wr_flt(1, 8'h40, 8'h20, 1);
    wr_flt(2, 8'h09, 8'h00, 0);
    send(8'h28);
    chk("R4 exact match dropped", count, 2);
    send(8'h60);
    chk("R4 masked match dropped", count, 2);
    send(8'h41);
    chk("R4 near miss stored", count, 3);
    send(8'h09);
    chk("R5 disabled entry ignored", count, 4);
    drain("R2 R3 record readback");

    filter_en = 0;
    send(8'h28);
    chk("R6 filter off stores match", count, 5);
    filter_en = 1;
    capture_en = 0;
    send(8'h05);
    chk("R7 capture off no store", count, 5);
    capture_en = 1;

    send(8'h10); send(8'h11);
    chk("R11 one per stored command", count, 7);
    send(8'h12);
    chk("R9 full count", count, TD);
    send(8'h13); send(8'h14);
    chk("R9 count saturates", count, TD);
    drain("R9 records unchanged after full");

    @(negedge clk);
    clear = 1; cmd_valid = 1; cmd_byte = 8'h33;
    @(negedge clk);
    clear = 0; cmd_valid = 0;
    cnt = 0; rd_base = 0;
    chk("R8 clear with command", count, 0);

    wr_flt(0, 8'h28, 8'h00, 0);
    send(8'h28);
    chk("R10 rewritten entry no longer drops", count, 1);
    wr_flt(3, 8'h77, 8'h00, 1);
    send(8'h77);
    chk("R10 new entry drops next cycle", count, 1);
    drain("R8 R2 first record after clear at address 0");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule